// File: doc/BRIEF.md
# SPI Command-Pair Slave

This block is an SPI slave (clock idle low, data sampled on the rising edge, changed on the falling edge) that sits between a bus master and a slower local peripheral. The master talks to it in fixed pairs of 8-bit transfers. The first byte is a command. The second byte either carries a payload or is a filler byte that clocks out a response. Payload bytes go into an inbound queue, tagged as plain data or as a peripheral command, and the peripheral drains that queue at its own pace. The peripheral hands back one result byte at a time through a reply holding register. While a result waits there, an interrupt line is raised so that the host does not need to poll.

The SPI pins are oversampled by the system clock, so the unit decodes and answers on its own. It keeps answering status queries when the peripheral is busy or stalled. Decoding depends on an internal pending-operand state and not on select edges. A byte counts as a command whenever no operand is outstanding. The master must leave a short gap between the command transfer and the operand transfer. Within that gap the slave loads its response into the shift register.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, miso, irq and in_valid are 0 and rep_ready is 1.
- R2: Command 0x01 followed by a byte B queues B with in_is_cmd=0. Queued bytes leave in arrival order, and an entry stays visible until in_pop is asserted.
- R3: Command 0x02 followed by a byte B queues B with in_is_cmd=1.
- R4: Command 0x04 returns the status byte on the second transfer. Bit 7 = reply waiting, bit 6 = overflow, bit 5 = per_busy, bit 4 = queue full, bits 3:0 = queue occupancy. It answers this way even while per_busy is high.
- R5: Command 0x05 returns the waiting reply byte on the second transfer and empties the holding register. If no reply is waiting, it returns 0x00.
- R6: irq is high exactly while a reply is waiting. A rep_push while a reply is already held is ignored, and rep_ready shows whether a push will be taken.
- R7: A data or peripheral-command write into a full queue is dropped and sets the overflow bit. A status read clears that bit after reporting it.
- R8: Command 0x00 and unknown codes are ignored, the slave replies 0x00 to them, and the following byte is decoded as a new command.
- R9: The byte shifted out during a command transfer is 0x00. The second byte of a 0x04 or 0x05 pair is discarded and is not queued.
- R10: An operand still counts as the operand of the previous command when select is released and asserted again between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master, low when not selected |
| in_valid | output | 1 | Inbound queue holds at least one entry |
| in_data | output | 8 | Head entry of the inbound queue |
| in_is_cmd | output | 1 | Head entry came from a peripheral-command write |
| in_pop | input | 1 | Peripheral removes the head entry |
| rep_push | input | 1 | Peripheral offers a reply byte |
| rep_data | input | 8 | Reply byte |
| rep_ready | output | 1 | Reply holding register is empty |
| per_busy | input | 1 | Peripheral operational state, reported in status |
| irq | output | 1 | Reply waiting for the master |

## Verification
On every cycle the assertions check several properties. The queue occupancy never exceeds its depth. A queued entry never disappears without a pop. A held reply survives an ignored push. irq rises only after a push and falls only while the slave is selected. The overflow bit rises only while the queue is full. The bench's scenarios cover the rest: the bytes the master actually receives over the link, the exact status encoding, the drop of the fifth write into a full queue, recovery after unknown codes, and an operand that arrives across a select release.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       ss_n,
  output logic       miso,
  output logic       in_valid,
  output logic [7:0] in_data,
  output logic       in_is_cmd,
  input  logic       in_pop,
  input  logic       rep_push,
  input  logic [7:0] rep_data,
  output logic       rep_ready,
  input  logic       per_busy,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {P_NONE, P_DATA, P_PCMD, P_DISC} pend_t;

  logic [2:0] sck_q;
  logic [1:0] mosi_q, ss_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh, tx_next, rx_byte, status, rep_q;
  pend_t      pend;
  logic       ovf, rep_valid;
  logic [8:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire sel       = !ss_q[1];
  wire rise      = sel && (sck_q[2:1] == 2'b01);
  wire fall      = sel && (sck_q[2:1] == 2'b10);
  wire byte_done = rise && (bit_cnt == 3'd7);
  wire as_cmd    = (pend == P_NONE);
  wire q_full    = (cnt == CW'(DEPTH));
  wire q_push    = byte_done && (pend == P_DATA || pend == P_PCMD);
  wire q_acc     = q_push && !q_full;
  wire q_drop    = q_push && q_full;
  wire pop_ok    = in_pop && (cnt != '0);

  assign rx_byte = {rx_sh, mosi_q[1]};
  wire rd_stat = byte_done && as_cmd && (rx_byte == 8'h04);
  wire rd_data = byte_done && as_cmd && (rx_byte == 8'h05);

  assign status  = {rep_valid, ovf, per_busy, q_full, 4'(cnt)};
  assign tx_next = rd_stat ? status : ((rd_data && rep_valid) ? rep_q : 8'h00);

  assign miso      = sel & tx_sh[7];
  assign irq       = rep_valid;
  assign rep_ready = !rep_valid;
  assign in_valid  = (cnt != '0);
  assign {in_is_cmd, in_data} = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      ss_q   <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sclk};
      mosi_q <= {mosi_q[0], mosi};
      ss_q   <= {ss_q[0], ss_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (!sel) bit_cnt <= '0;
      else if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {rx_sh[5:0], mosi_q[1]};
      end
      if (byte_done) tx_sh <= tx_next;
      else if (fall && bit_cnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= P_NONE;
    else if (byte_done) begin
      if (as_cmd) begin
        case (rx_byte)
          8'h01:        pend <= P_DATA;
          8'h02:        pend <= P_PCMD;
          8'h04, 8'h05: pend <= P_DISC;
          default:      pend <= P_NONE;
        endcase
      end else pend <= P_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf       <= 1'b0;
      rep_valid <= 1'b0;
      rep_q     <= '0;
    end else begin
      if (q_drop) ovf <= 1'b1;
      else if (rd_stat) ovf <= 1'b0;
      if (rd_data && rep_valid) rep_valid <= 1'b0;
      else if (rep_push && !rep_valid) begin
        rep_valid <= 1'b1;
        rep_q     <= rep_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (q_acc) begin
        mem[wp] <= {(pend == P_PCMD), rx_byte};
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      end
      if (pop_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(q_acc) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic rep_ready,
  input logic rep_push,
  input logic in_valid,
  input logic in_pop,
  input logic sel,
  input logic ovf,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  assert_entry_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_pop |=> in_valid);
  assert_irq_fall_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sel));
  assert_irq_from_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rep_push));
  assert_reply_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push && !rep_ready && !sel |=> !rep_ready);
  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));
  assert_ovf_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(cnt) == ($clog2(DEPTH+1))'(DEPTH)));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rep_ready(rep_ready),
  .rep_push(rep_push), .in_valid(in_valid), .in_pop(in_pop),
  .sel(sel), .ovf(ovf), .cnt(cnt)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, ss_n = 1;
  logic in_pop = 0, rep_push = 0, per_busy = 0;
  logic [7:0] rep_data = 0;
  logic miso, in_valid, in_is_cmd, rep_ready, irq;
  logic [7:0] in_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_cmd_slave #(.DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .in_valid(in_valid), .in_data(in_data), .in_is_cmd(in_is_cmd), .in_pop(in_pop),
    .rep_push(rep_push), .rep_data(rep_data), .rep_ready(rep_ready),
    .per_busy(per_busy), .irq(irq)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wclk(8);
      rx[i] = miso;
      sclk = 1;
      wclk(8);
      sclk = 0;
    end
    wclk(12);
  endtask

  task automatic pair(input logic [7:0] c, input logic [7:0] op,
                      output logic [7:0] r0, output logic [7:0] r1);
    ss_n = 0; wclk(4);
    xfer(c, r0);
    xfer(op, r1);
    ss_n = 1; wclk(6);
  endtask

  task automatic pop();
    in_pop = 1; wclk(1); in_pop = 0; wclk(1);
  endtask

  task automatic push(input logic [7:0] d);
    rep_data = d; rep_push = 1; wclk(1); rep_push = 0; wclk(1);
  endtask

  task automatic t_reset();
    chk("R1 miso", {8'h0, miso}, 9'h0);
    chk("R1 irq", {8'h0, irq}, 9'h0);
    chk("R1 in_valid", {8'h0, in_valid}, 9'h0);
    chk("R1 rep_ready", {8'h0, rep_ready}, 9'h1);
  endtask

  task automatic t_status_busy();
    logic [7:0] a, b;
    per_busy = 1;
    pair(8'h04, 8'h00, a, b);
    chk("R9 command-phase byte", {1'b0, a}, 9'h000);
    chk("R4 status busy", {1'b0, b}, 9'h020);
    per_busy = 0;
    chk("R9 null operand not queued", {8'h0, in_valid}, 9'h0);
  endtask

  task automatic t_queue_order();
    logic [7:0] a, b;
    pair(8'h01, 8'hA5, a, b);
    pair(8'h02, 8'h3C, a, b);
    chk("R2 head data", {in_is_cmd, in_data}, {1'b0, 8'hA5});
    wclk(20);
    chk("R2 head held", {in_is_cmd, in_data}, {1'b0, 8'hA5});
    pop();
    chk("R3 cmd entry", {in_is_cmd, in_data}, {1'b1, 8'h3C});
    pop();
    chk("R2 queue empty", {8'h0, in_valid}, 9'h0);
  endtask

  task automatic t_overflow();
    logic [7:0] a, b;
    pair(8'h01, 8'h11, a, b);
    pair(8'h02, 8'h22, a, b);
    pair(8'h01, 8'h33, a, b);
    pair(8'h01, 8'h44, a, b);
    pair(8'h01, 8'h55, a, b);
    pair(8'h04, 8'h00, a, b);
    chk("R7 status full+ovf", {1'b0, b}, 9'h054);
    pair(8'h04, 8'h00, a, b);
    chk("R7 ovf cleared", {1'b0, b}, 9'h014);
    chk("R7 first", {in_is_cmd, in_data}, {1'b0, 8'h11}); pop();
    chk("R7 second", {in_is_cmd, in_data}, {1'b1, 8'h22}); pop();
    chk("R7 third", {in_is_cmd, in_data}, {1'b0, 8'h33}); pop();
    chk("R7 fourth", {in_is_cmd, in_data}, {1'b0, 8'h44}); pop();
    chk("R7 fifth dropped", {8'h0, in_valid}, 9'h0);
  endtask

  task automatic t_reply();
    logic [7:0] a, b;
    pair(8'h05, 8'h00, a, b);
    chk("R5 no reply gives zero", {1'b0, b}, 9'h000);
    push(8'h5A);
    chk("R6 irq set", {8'h0, irq}, 9'h1);
    chk("R6 not ready", {8'h0, rep_ready}, 9'h0);
    push(8'h77);
    pair(8'h04, 8'h00, a, b);
    chk("R4 status reply bit", {1'b0, b}, 9'h080);
    pair(8'h05, 8'h00, a, b);
    chk("R6 R5 held reply", {1'b0, b}, 9'h05A);
    chk("R5 irq cleared", {8'h0, irq}, 9'h0);
    chk("R5 ready again", {8'h0, rep_ready}, 9'h1);
    chk("R9 read operand not queued", {8'h0, in_valid}, 9'h0);
  endtask

  task automatic t_unknown();
    logic [7:0] a, b, c;
    ss_n = 0; wclk(4);
    xfer(8'h33, a);
    xfer(8'h00, b);
    chk("R8 reply to unknown", {1'b0, b}, 9'h000);
    xfer(8'h01, b);
    chk("R8 reply to null", {1'b0, b}, 9'h000);
    xfer(8'hAB, c);
    ss_n = 1; wclk(6);
    chk("R8 next byte is command", {in_is_cmd, in_data}, {1'b0, 8'hAB});
    pop();
    chk("R8 only one entry", {8'h0, in_valid}, 9'h0);
  endtask

  task automatic t_ss_gap();
    logic [7:0] a;
    ss_n = 0; wclk(4);
    xfer(8'h02, a);
    ss_n = 1; wclk(20);
    ss_n = 0; wclk(4);
    xfer(8'hC3, a);
    ss_n = 1; wclk(6);
    chk("R10 operand across select", {in_is_cmd, in_data}, {1'b1, 8'hC3});
    pop();
  endtask

  initial begin
    wclk(3);
    rst_n = 1;
    wclk(3);
    t_reset();
    t_status_busy();
    t_queue_order();
    t_overflow();
    t_reply();
    t_unknown();
    t_ss_gap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule